// File: doc/BRIEF.md
# Vector Floating-Point Sign Injection Unit

This block rebuilds the sign of every element of a packed vector register value. Each element keeps all of its bits except the top one unchanged from the vector source. Its new sign bit comes from a scalar floating-point operand in one of three ways: copied, inverted, or XORed with the element's own sign. No rounding takes place, and the result is formed by bit manipulation alone. It therefore produces no floating-point exception flags and reads neither rounding mode.

The caller supplies the packed source, the scalar operand, an element-width code (16, 32 or 64 bits), the active vector length, the mask enable and the mask register, one policy bit for tail elements and one for masked-off elements, the old destination value and the variant code. The block computes the new destination in one combinational pass and registers it. The result is returned through a valid/ready pair one cycle after the request is accepted. Instruction decode, register-file access and register grouping belong to the surrounding pipeline.

Top module: `vsign_inject`

## Requirements
- R1: For every active element, bits W-2..0 of the result equal the same bits of the source element, where element i of width W occupies bits [i*W +: W] of the packed vectors.
- R2: With variant code 0 (code 3 behaves identically), the sign of an active element equals the scalar sign.
- R3: With variant code 1, the sign of an active element equals the inverse of the scalar sign.
- R4: With variant code 2, the sign of an active element equals the scalar sign XOR the source element's sign bit.
- R5: The scalar sign is bit W-1 of the scalar. When W is below the scalar width and the scalar bits above W-1 are not all ones, the scalar is taken as the canonical NaN and its sign is 0.
- R6: An element whose index is at or above vl is a tail element. It becomes all ones when tail_agn is 1 and keeps its old destination value when tail_agn is 0.
- R7: When mask_en_n is 0, an element below vl whose bit in mask_v0 is 0 is inactive. It becomes all ones when inact_agn is 1 and keeps its old value when inact_agn is 0.
- R8: When mask_en_n is 1, every element below vl is active whatever mask_v0 holds.
- R9: sew code 0 selects 16-bit, 1 selects 32-bit and 2 selects 64-bit elements. Code 3, and code 0 when FP16_EN is 0, returns old_dst unchanged.
- R10: When vl is 0, the result equals old_dst regardless of policy, and a response is still produced.
- R11: req_ready equals (not resp_valid) or resp_ready. An accepted request drives resp_valid high with its result on dst_out at the next clock edge. The response is held stable while resp_ready is low. After reset, resp_valid and dst_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| src_vec | input | VLEN | Packed vector source elements |
| scalar | input | ELEN | Scalar floating-point operand |
| sew | input | 2 | Element width code: 0=16, 1=32, 2=64 |
| vl | input | $clog2(VLEN/16+1) | Number of body elements |
| mask_en_n | input | 1 | 1 = unmasked, 0 = mask_v0 gates elements |
| mask_v0 | input | VLEN/16 | Per-element enable bits |
| tail_agn | input | 1 | Tail policy: 1 = fill ones, 0 = keep old |
| inact_agn | input | 1 | Inactive policy: 1 = fill ones, 0 = keep old |
| old_dst | input | VLEN | Previous destination value |
| variant | input | 2 | 0 copy, 1 negate, 2 XOR |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Result can be taken |
| dst_out | output | VLEN | Packed result |

## Verification
Each result appears on dst_out one clock edge after the edge that accepts its request. The bench therefore applies a request at a falling edge, lets one rising edge pass, and compares every element at the following falling edge, where resp_valid must already be high. The sweep covers all width codes, all variant codes, vl from 0 up to past the element count, both mask modes, all four policy combinations and boxed and unboxed scalars. A stall case keeps resp_ready low for a cycle and checks that the first result stays in place while a second request waits. That request is then taken at the same edge that consumes the first result.

// File: rtl/vsgn_pkg.sv
package vsgn_pkg;
    typedef enum logic [1:0] {
        SEW_16  = 2'd0,
        SEW_32  = 2'd1,
        SEW_64  = 2'd2,
        SEW_BAD = 2'd3
    } sew_e;

    typedef enum logic [1:0] {
        SGN_COPY = 2'd0,
        SGN_NEG  = 2'd1,
        SGN_XOR  = 2'd2,
        SGN_RSV  = 2'd3
    } sgn_op_e;
endpackage

// File: rtl/vsgn_lane.sv
module vsgn_lane
    import vsgn_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] elem,
    input  logic [W-1:0] old,
    input  logic         ssign,
    input  sgn_op_e      op,
    input  logic         in_body,
    input  logic         active,
    input  logic         tail_agn,
    input  logic         inact_agn,
    output logic [W-1:0] res
);
    logic new_sign;

    // sign selection for the three variants
    always_comb begin
        unique case (op)
            SGN_NEG: new_sign = ~ssign;
            SGN_XOR: new_sign = ssign ^ elem[W-1];
            default: new_sign = ssign;
        endcase
    end

    // policy: tail first, then mask, then computed value
    always_comb begin
        if (!in_body) begin
            res = tail_agn ? '1 : old;
        end else if (!active) begin
            res = inact_agn ? '1 : old;
        end else begin
            res = {new_sign, elem[W-2:0]};
        end
    end
endmodule

// File: rtl/vsgn_slice.sv
module vsgn_slice
    import vsgn_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int W     = 32,
    parameter int MAXEL = VLEN / 16,
    parameter int VLW   = $clog2(MAXEL + 1)
) (
    input  logic [VLEN-1:0]  src_vec,
    input  logic [VLEN-1:0]  old_vec,
    input  logic [ELEN-1:0]  scalar,
    input  sgn_op_e          op,
    input  logic [VLW-1:0]   vl,
    input  logic             mask_en_n,
    input  logic [MAXEL-1:0] mask_v0,
    input  logic             tail_agn,
    input  logic             inact_agn,
    output logic [VLEN-1:0]  res
);
    localparam int NE = VLEN / W;

    logic ssign;
    logic unused_bits;

    // scalar sign with NaN-box validation
    generate
        if (W < ELEN) begin : g_boxed
            logic boxed;
            assign boxed = &scalar[ELEN-1:W];
            assign ssign = boxed & scalar[W-1];
        end else begin : g_full
            assign ssign = scalar[ELEN-1];
        end
        if (NE < MAXEL) begin : g_mask_rest
            assign unused_bits = ^{scalar[W-2:0], mask_v0[MAXEL-1:NE]};
        end else begin : g_mask_all
            assign unused_bits = ^scalar[W-2:0];
        end
    endgenerate

    genvar gi;
    generate
        for (gi = 0; gi < NE; gi++) begin : g_lane
            localparam logic [VLW-1:0] IDX = VLW'(gi);
            logic body;
            logic act;
            assign body = IDX < vl;
            assign act  = mask_en_n | mask_v0[gi];
            vsgn_lane #(.W(W)) i_lane (
                .elem      (src_vec[gi*W +: W]),
                .old       (old_vec[gi*W +: W]),
                .ssign     (ssign),
                .op        (op),
                .in_body   (body),
                .active    (act),
                .tail_agn  (tail_agn),
                .inact_agn (inact_agn),
                .res       (res[gi*W +: W])
            );
        end
    endgenerate
endmodule

// File: rtl/vsign_inject.sv
module vsign_inject
    import vsgn_pkg::*;
#(
    parameter int VLEN    = 128,
    parameter int ELEN    = 64,
    parameter bit FP16_EN = 1'b1,
    parameter int MAXEL   = VLEN / 16,
    parameter int VLW     = $clog2(MAXEL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VLEN-1:0]  src_vec,
    input  logic [ELEN-1:0]  scalar,
    input  logic [1:0]       sew,
    input  logic [VLW-1:0]   vl,
    input  logic             mask_en_n,
    input  logic [MAXEL-1:0] mask_v0,
    input  logic             tail_agn,
    input  logic             inact_agn,
    input  logic [VLEN-1:0]  old_dst,
    input  logic [1:0]       variant,
    output logic             resp_valid,
    input  logic             resp_ready,
    output logic [VLEN-1:0]  dst_out
);
    typedef struct packed {
        logic            valid;
        logic [VLEN-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic [VLEN-1:0] res_w [3];
    logic [VLEN-1:0] result;
    sgn_op_e op;

    assign op = sgn_op_e'(variant);

    genvar gw;
    generate
        for (gw = 0; gw < 3; gw++) begin : g_width
            vsgn_slice #(
                .VLEN(VLEN), .ELEN(ELEN), .W(16 << gw), .MAXEL(MAXEL), .VLW(VLW)
            ) i_slice (
                .src_vec   (src_vec),
                .old_vec   (old_dst),
                .scalar    (scalar),
                .op        (op),
                .vl        (vl),
                .mask_en_n (mask_en_n),
                .mask_v0   (mask_v0),
                .tail_agn  (tail_agn),
                .inact_agn (inact_agn),
                .res       (res_w[gw])
            );
        end
    endgenerate

    always_comb begin
        if (vl == '0) begin
            result = old_dst;
        end else begin
            unique case (sew_e'(sew))
                SEW_16:  result = FP16_EN ? res_w[0] : old_dst;
                SEW_32:  result = res_w[1];
                SEW_64:  result = res_w[2];
                default: result = old_dst;
            endcase
        end
    end

    assign req_ready = !st_q.valid || resp_ready;

    always_comb begin
        st_d = st_q;
        if (resp_ready) begin
            st_d.valid = 1'b0;
        end
        if (req_valid && req_ready) begin
            st_d.valid = 1'b1;
            st_d.data  = result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.valid;
    assign dst_out    = st_q.data;

    // R11: accepted request yields a response next cycle
    assert_accept_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    // R11: stalled response is held
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(dst_out)));

    // R10: zero length leaves destination unchanged
    assert_vl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && vl == '0) |=> (dst_out == $past(old_dst)));

    // R1: magnitude of 32-bit element 0 passes through
    assert_magnitude_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && vl != '0 && sew == 2'd1 && (mask_en_n || mask_v0[0]))
        |=> (dst_out[30:0] == $past(src_vec[30:0])));

    // R6: agnostic tail of 64-bit element 1 is all ones
    generate
        if (VLEN >= 128) begin : g_tail_chk
            assert_tail_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_ready && sew == 2'd2 && vl == VLW'(1) && tail_agn)
                |=> (&dst_out[127:64]));
        end
    endgenerate
endmodule

// File: tb/test_vsign_inject.sv
`timescale 1ns/1ps
module test_vsign_inject;
    localparam int VLEN = 128;
    localparam int ELEN = 64;
    localparam int NEL  = VLEN / 16;
    localparam int VLW  = $clog2(NEL + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic             req_ready;
    logic [VLEN-1:0]  src_vec;
    logic [ELEN-1:0]  scalar;
    logic [1:0]       sew;
    logic [VLW-1:0]   vl;
    logic             mask_en_n;
    logic [NEL-1:0]   mask_v0;
    logic             tail_agn;
    logic             inact_agn;
    logic [VLEN-1:0]  old_dst;
    logic [1:0]       variant;
    logic             resp_valid;
    logic             resp_ready;
    logic [VLEN-1:0]  dst_out;

    int errs = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1BAD_C0DE;

    always #2.5 clk = ~clk;

    vsign_inject #(.VLEN(VLEN), .ELEN(ELEN), .FP16_EN(1'b1)) i_vsign_inject (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .src_vec(src_vec), .scalar(scalar), .sew(sew), .vl(vl),
        .mask_en_n(mask_en_n), .mask_v0(mask_v0), .tail_agn(tail_agn),
        .inact_agn(inact_agn), .old_dst(old_dst), .variant(variant),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .dst_out(dst_out)
    );

    task automatic check(input bit ok, input string req,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        return lfsr;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic run_one(input int s, input int op, input int vlen_in, input bit vm,
                           input bit tp, input bit mp, input logic [63:0] sc);
        int w, ne;
        logic [63:0] msk, a, es, eo, exp, mag;
        bit ssign, boxed, esign;
        string tag;
        @(negedge clk);
        src_vec   = {next_rand(), next_rand(), next_rand(), next_rand()};
        old_dst   = {next_rand(), next_rand(), next_rand(), next_rand()};
        mask_v0   = NEL'(next_rand());
        scalar    = sc;
        sew       = 2'(s);
        variant   = 2'(op);
        vl        = VLW'(vlen_in);
        mask_en_n = vm;
        tail_agn  = tp;
        inact_agn = mp;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid === 1'b1, "R11 resp_valid after accept", VLEN'(resp_valid), VLEN'(1));
        if (s == 3) begin
            check(dst_out === old_dst, "R9 reserved width code", dst_out, old_dst);
            return;
        end
        if (vlen_in == 0) begin
            check(dst_out === old_dst, "R10 zero length", dst_out, old_dst);
            return;
        end
        w   = 16 << s;
        ne  = VLEN / w;
        msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << w) - 64'h1);
        mag = msk >> 1;
        if (w == 64) begin
            boxed = 1'b1;
            ssign = sc[63];
        end else begin
            boxed = ((sc >> w) == ((64'h1 << (64 - w)) - 64'h1));
            ssign = boxed & sc[w-1];
        end
        for (int i = 0; i < ne; i++) begin
            a  = 64'(dst_out >> (i * w)) & msk;
            es = 64'(src_vec >> (i * w)) & msk;
            eo = 64'(old_dst >> (i * w)) & msk;
            if (i >= vlen_in) begin
                exp = tp ? msk : eo;
                check(a === exp, "R6 tail element", VLEN'(a), VLEN'(exp));
            end else if (!vm && !mask_v0[i]) begin
                exp = mp ? msk : eo;
                check(a === exp, "R7 inactive element", VLEN'(a), VLEN'(exp));
            end else begin
                check((a & mag) === (es & mag), "R1 magnitude",
                      VLEN'(a & mag), VLEN'(es & mag));
                case (op)
                    1: begin esign = ~ssign; tag = "R3 negated sign"; end
                    2: begin esign = ssign ^ es[w-1]; tag = "R4 xor sign"; end
                    default: begin esign = ssign; tag = "R2 copied sign"; end
                endcase
                if (!boxed) tag = {tag, " R5 unboxed scalar"};
                if (vm && !mask_v0[i]) tag = {tag, " R8 mask ignored"};
                check(a[w-1] === esign, tag, VLEN'(a[w-1]), VLEN'(esign));
            end
        end
    endtask

    initial begin
        logic [63:0] scs [3];
        scs[0] = 64'hFFFF_FFFF_FFFF_8123;
        scs[1] = 64'h0000_0000_0000_8001;
        scs[2] = 64'hFFFF_FFFF_0000_4000;
        rst_n = 1'b0; req_valid = 1'b0; resp_ready = 1'b1;
        src_vec = '0; scalar = '0; sew = '0; vl = '0; mask_en_n = 1'b1;
        mask_v0 = '0; tail_agn = 1'b0; inact_agn = 1'b0; old_dst = '0; variant = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(resp_valid === 1'b0, "R11 reset valid", VLEN'(resp_valid), '0);
        check(dst_out === '0, "R11 reset data", dst_out, '0);
        check(req_ready === 1'b1, "R11 ready after reset", VLEN'(req_ready), VLEN'(1));
        rst_n = 1'b1;

        for (int s = 0; s < 4; s++)
            for (int op = 0; op < 4; op++)
                for (int v = 0; v <= NEL + 1; v++)
                    for (int m = 0; m < 2; m++)
                        for (int p = 0; p < 4; p++)
                            for (int k = 0; k < 3; k++)
                                run_one(s, op, v, m[0], p[0], p[1], scs[k]);

        // R11 stall: first result held while second request waits
        @(negedge clk);
        resp_ready = 1'b0;
        src_vec = {4{32'h0123_4567}}; old_dst = '0; scalar = 64'hFFFF_FFFF_8000_0000;
        sew = 2'd1; variant = 2'd0; vl = VLW'(4); mask_en_n = 1'b1;
        tail_agn = 1'b0; inact_agn = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        src_vec = {4{32'h8765_4321}}; variant = 2'd1;
        check(req_ready === 1'b0, "R11 ready low in stall", VLEN'(req_ready), '0);
        check(dst_out === {4{32'h8123_4567}}, "R11 first result", dst_out, {4{32'h8123_4567}});
        @(posedge clk);
        @(negedge clk);
        check(resp_valid === 1'b1 && dst_out === {4{32'h8123_4567}}, "R11 held during stall",
              dst_out, {4{32'h8123_4567}});
        resp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(dst_out === {4{32'h0765_4321}}, "R11 second result after release",
              dst_out, {4{32'h0765_4321}});
        @(posedge clk);
        @(negedge clk);
        check(resp_valid === 1'b0, "R11 valid drops when consumed", VLEN'(resp_valid), '0);
        finish_run();
    end
endmodule